// File: doc/BRIEF.md
# NAND Flash Bus Cycle Decoder

This block is the device-side front end of an asynchronous 8-bit NAND flash bus. It runs on a fast internal clock and passes every pad input (chip enable, command latch, address latch, read enable, write enable and the 8-bit I/O bus) through the same multi-flop synchronizer. Each rising edge of the write strobe is then sorted into a command, address or data cycle. The sort uses the levels of the other control pins at the clock where the edge is seen.

A command cycle latches the byte and raises a one-clock command pulse. It also restarts address collection. Address cycles fill a 24-bit address low byte first. When the third byte arrives, a one-clock completion pulse is raised. A surplus address byte is reported as a protocol error. Data cycles are handed to a downstream page buffer as single-clock valid pulses. Each pulse carries the byte and a 9-bit column index. The index restarts at zero whenever an address completes.

Top module: `nand_bus_decoder`

## Requirements
- R1: After reset all pulse outputs are low, and `addr_o`, `cmd_o`, `data_o` and `col_o` are zero.
- R2: A write-strobe rising edge with chip enable low (`ce_n_i`=0), `cle_i`=1, `ale_i`=0 and `re_n_i`=1 produces exactly one single-clock `cmd_valid_o` pulse with `cmd_o` equal to the I/O byte. `cmd_o` changes only together with that pulse.
- R3: Strobes with `ce_n_i`=0, `ale_i`=1, `cle_i`=0 and `re_n_i`=1 are address cycles. The first, second and third of them load bits 7:0, 15:8 and 23:16 of `addr_o`. The third also raises `addr_done_o` for one clock, and `addr_o` then holds all three bytes.
- R4: An address cycle that arrives after three address bytes with no command in between raises `proto_err_o` for one clock. It leaves `addr_o` unchanged and raises no `addr_done_o`.
- R5: A command cycle resets the address byte count, so the next three address cycles form a new complete address.
- R6: A strobe with `ce_n_i`=0, `cle_i`=0, `ale_i`=0 and `re_n_i`=1 raises `data_valid_o` for one clock with `data_o` equal to the I/O byte and `col_o` equal to the current column. The column then advances by one.
- R7: The column is zero for the first data byte after reset and for the first data byte after each address completion.
- R8: A strobe with `ce_n_i`=1, with `re_n_i`=0, or with both `cle_i` and `ale_i` high produces no output pulse. It changes neither the address count nor the column.
- R9: The 9-bit column wraps from 511 to 0.
- R10: Each write-strobe rising edge produces at most one of the four pulses. The pulses are never high together, and a falling write strobe produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable pad, active low |
| cle_i | input | 1 | Command latch enable pad |
| ale_i | input | 1 | Address latch enable pad |
| re_n_i | input | 1 | Read enable pad, active low |
| we_n_i | input | 1 | Write strobe pad, captures on rising edge |
| io_i | input | 8 | I/O bus pad |
| cmd_valid_o | output | 1 | Command byte captured (one clock) |
| cmd_o | output | 8 | Last command byte |
| addr_done_o | output | 1 | Third address byte captured (one clock) |
| addr_o | output | 24 | Assembled address |
| proto_err_o | output | 1 | Surplus address byte seen (one clock) |
| data_valid_o | output | 1 | Data byte valid (one clock) |
| data_o | output | 8 | Data byte |
| col_o | output | 9 | Column index of the data byte |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, three address cycles, a 9-bit column and a two-stage synchronizer. A 9-bit column makes the wrap after 512 data bytes reachable in a few thousand clocks. The three-cycle address lets the surplus-byte error and the reset of the byte count by a command be reached with short sequences. Ignored strobes are placed in the middle of address and data runs, so any state they disturb appears in the following address or column values.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2,
    CYC_DATA = 2'd3
  } cyc_e;
endpackage

// File: rtl/nand_in_sync.sv
module nand_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nand_cycle_classify.sv
module nand_cycle_classify
  import nand_dec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_n_s_i,
  input  logic ce_n_s_i,
  input  logic cle_s_i,
  input  logic ale_s_i,
  input  logic re_n_s_i,
  output cyc_e cyc_o
);
  logic we_n_d_q;
  logic strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_n_d_q <= 1'b1;
    else         we_n_d_q <= we_n_s_i;
  end

  assign strobe = we_n_s_i & ~we_n_d_q;

  always_comb begin
    cyc_o = CYC_NONE;
    if (strobe && !ce_n_s_i && re_n_s_i) begin
      unique case ({cle_s_i, ale_s_i})
        2'b10:   cyc_o = CYC_CMD;
        2'b01:   cyc_o = CYC_ADDR;
        2'b00:   cyc_o = CYC_DATA;
        default: cyc_o = CYC_NONE; // both latches high: ignored
      endcase
    end
  end
endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect
  import nand_dec_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_CYCLES = 3,
  localparam int unsigned ADDR_W     = DATA_W * ADDR_CYCLES,
  localparam int unsigned CNT_W      = $clog2(ADDR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              complete_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, err_q;
  logic              room;

  assign room       = (cnt_q < CNT_W'(ADDR_CYCLES));
  assign complete_o = (cyc_i == CYC_ADDR) && (cnt_q == CNT_W'(ADDR_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cyc_i == CYC_CMD) begin
        cnt_q <= '0;
      end else if (cyc_i == CYC_ADDR) begin
        if (room) begin
          addr_q[int'(cnt_q)*DATA_W +: DATA_W] <= byte_i;
          cnt_q  <= cnt_q + 1'b1;
          done_q <= complete_o;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/nand_data_stream.sv
module nand_data_stream
  import nand_dec_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COL_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              col_clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [COL_W-1:0]  col_o
);
  logic [COL_W-1:0]  next_col_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_col_q <= '0;
      col_q      <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (col_clr_i) begin
        next_col_q <= '0;
      end else if (cyc_i == CYC_DATA) begin
        valid_q    <= 1'b1;
        data_q     <= byte_i;
        col_q      <= next_col_q;
        next_col_q <= next_col_q + 1'b1; // wraps at 2**COL_W
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign col_o   = col_q;
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
  import nand_dec_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_CYCLES = 3,
  parameter int unsigned COL_W       = 9,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = DATA_W * ADDR_CYCLES,
  localparam int unsigned PAD_W      = DATA_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic              re_n_i,
  input  logic              we_n_i,
  input  logic [DATA_W-1:0] io_i,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              addr_done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              proto_err_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [COL_W-1:0]  col_o
);
  // pad vector: {ce_n, cle, ale, re_n, we_n, io}; idle levels on reset
  localparam logic [PAD_W-1:0] PAD_IDLE = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

  logic [PAD_W-1:0]  pad_s;
  logic [DATA_W-1:0] io_s;
  logic              ce_n_s, cle_s, ale_s, re_n_s, we_n_s;
  cyc_e              cyc;
  logic              addr_complete;
  logic              cmd_valid_q;
  logic [DATA_W-1:0] cmd_q;

  nand_in_sync #(
    .W      (PAD_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PAD_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_n_i, cle_i, ale_i, re_n_i, we_n_i, io_i}),
    .q_o   (pad_s)
  );

  assign {ce_n_s, cle_s, ale_s, re_n_s, we_n_s, io_s} = pad_s;

  nand_cycle_classify u_classify (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_n_s_i(we_n_s),
    .ce_n_s_i(ce_n_s),
    .cle_s_i (cle_s),
    .ale_s_i (ale_s),
    .re_n_s_i(re_n_s),
    .cyc_o   (cyc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_q       <= '0;
    end else begin
      cmd_valid_q <= (cyc == CYC_CMD);
      if (cyc == CYC_CMD) cmd_q <= io_s;
    end
  end

  nand_addr_collect #(
    .DATA_W     (DATA_W),
    .ADDR_CYCLES(ADDR_CYCLES)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_i     (cyc),
    .byte_i    (io_s),
    .complete_o(addr_complete),
    .done_o    (addr_done_o),
    .err_o     (proto_err_o),
    .addr_o    (addr_o)
  );

  nand_data_stream #(
    .DATA_W(DATA_W),
    .COL_W (COL_W)
  ) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_i    (cyc),
    .byte_i   (io_s),
    .col_clr_i(addr_complete),
    .valid_o  (data_valid_o),
    .data_o   (data_o),
    .col_o    (col_o)
  );

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;
endmodule

// File: rtl/nand_bus_decoder_chk.sv
module nand_bus_decoder_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned COL_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic [DATA_W-1:0] cmd_o,
  input logic              addr_done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              proto_err_o,
  input logic              data_valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [COL_W-1:0]  col_o
);
  a_r10_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, addr_done_o, proto_err_o, data_valid_o}));

  a_r2_cmd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  a_r2_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != $past(cmd_o)) |-> cmd_valid_o);

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_done_o |=> !addr_done_o);

  a_r4_err_keeps_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (addr_o == $past(addr_o)));

  a_r6_data_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_o != $past(data_o)) || (col_o != $past(col_o))) |-> data_valid_o);
endmodule

bind nand_bus_decoder nand_bus_decoder_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .COL_W (COL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_o       (cmd_o),
  .addr_done_o (addr_done_o),
  .addr_o      (addr_o),
  .proto_err_o (proto_err_o),
  .data_valid_o(data_valid_o),
  .data_o      (data_o),
  .col_o       (col_o)
);

// File: tb/nand_bus_decoder_tb.sv
module nand_bus_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, re_n = 1'b1, we_n = 1'b1;
  logic [7:0]  io = '0;
  logic        cmd_valid, addr_done, proto_err, data_valid;
  logic [7:0]  cmd, data;
  logic [23:0] addr;
  logic [8:0]  col;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // event records: {kind[3:0], value[31:0]}; kind 1 cmd, 2 done, 3 err, 4 data
  logic [35:0] got_q[$];
  logic [35:0] exp_q[$];

  // behavioural reference state
  int          m_acnt = 0;
  logic [23:0] m_addr = '0;
  int          m_col  = 0;

  always #10 clk = ~clk;

  nand_bus_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale), .re_n_i(re_n), .we_n_i(we_n), .io_i(io),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .addr_done_o(addr_done), .addr_o(addr), .proto_err_o(proto_err),
    .data_valid_o(data_valid), .data_o(data), .col_o(col)
  );

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid)  got_q.push_back({4'd1, 24'd0, cmd});
      if (addr_done)  got_q.push_back({4'd2, 8'd0, addr});
      if (proto_err)  got_q.push_back({4'd3, 8'd0, addr});
      if (data_valid) got_q.push_back({4'd4, 15'd0, col, data});
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // reference model of one strobe, from the requirements
  task automatic model(input logic c_n, input logic c, input logic a,
                       input logic r_n, input logic [7:0] b);
    if (c_n || !r_n || (c && a)) return;
    if (c) begin
      m_acnt = 0;
      exp_q.push_back({4'd1, 24'd0, b});
    end else if (a) begin
      if (m_acnt < 3) begin
        m_addr[m_acnt*8 +: 8] = b;
        m_acnt++;
        if (m_acnt == 3) begin
          m_col = 0;
          exp_q.push_back({4'd2, 8'd0, m_addr});
        end
      end else begin
        exp_q.push_back({4'd3, 8'd0, m_addr});
      end
    end else begin
      exp_q.push_back({4'd4, 15'd0, 9'(m_col), b});
      m_col = (m_col + 1) % 512;
    end
  endtask

  task automatic strobe(input string req, input logic c_n, input logic c, input logic a,
                        input logic r_n, input logic [7:0] b);
    @(negedge clk);
    ce_n = c_n; cle = c; ale = a; re_n = r_n; io = b;
    we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    model(c_n, c, a, r_n, b);
    repeat (6) @(negedge clk);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      fails++;
      $display("FAIL %s: actual %0d events expected %0d", req, got_q.size(), exp_q.size());
    end else begin
      while (exp_q.size() > 0) begin
        logic [35:0] g, e;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        if (g !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", req, g, e);
        end
      end
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic cmd_cyc(input string req, input logic [7:0] b);  strobe(req, 0, 1, 0, 1, b); endtask
  task automatic addr_cyc(input string req, input logic [7:0] b); strobe(req, 0, 0, 1, 1, b); endtask
  task automatic data_cyc(input string req, input logic [7:0] b); strobe(req, 0, 0, 0, 1, b); endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {cmd_valid, addr_done, proto_err, data_valid}, 4'b0);
    check("R1", {addr, cmd, data, 9'(col)}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 data before any address starts at column 0
    data_cyc("R7", 8'h11);
    data_cyc("R6", 8'h22);

    // R2 command decode
    cmd_cyc("R2", 8'h80);
    check("R2", 36'(cmd), 36'h80);

    // R3 address assembly, low byte first
    addr_cyc("R3", 8'h12);
    check("R3", 36'(addr[7:0]), 36'h12);
    addr_cyc("R3", 8'h34);
    addr_cyc("R3", 8'h56);
    check("R3", 36'(addr), 36'h563412);

    // R7 column restarts; R6 stream
    for (int i = 0; i < 4; i++) data_cyc("R6", 8'hA0 + 8'(i));

    // R4 surplus address byte
    addr_cyc("R4", 8'hEE);
    check("R4", 36'(addr), 36'h563412);

    // R5 command resets address count
    cmd_cyc("R5", 8'h00);
    addr_cyc("R5", 8'h01);
    // R8 ignored strobes mid-address
    strobe("R8", 1, 0, 1, 1, 8'hF1);
    strobe("R8", 0, 0, 1, 0, 8'hF2);
    strobe("R8", 0, 1, 1, 1, 8'hF3);
    addr_cyc("R5", 8'h02);
    addr_cyc("R5", 8'h03);
    check("R5", 36'(addr), 36'h030201);

    // R8 ignored strobes mid-data keep the column
    data_cyc("R8", 8'h5A);
    strobe("R8", 1, 0, 0, 1, 8'hF4);
    strobe("R8", 0, 0, 0, 0, 8'hF5);
    data_cyc("R8", 8'h5B);
    check("R8", 36'(col), 36'd1);

    // R9 column wrap: restart address then 513 bytes
    cmd_cyc("R9", 8'h80);
    addr_cyc("R9", 8'h00);
    addr_cyc("R9", 8'h00);
    addr_cyc("R9", 8'h00);
    for (int i = 0; i < 513; i++) data_cyc("R9", 8'(i));
    check("R9", 36'(col), 36'd0);

    // R10 falling strobe with no rise yields nothing
    @(negedge clk);
    ce_n = 0; cle = 1; ale = 0; re_n = 1; io = 8'h77;
    we_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R10", 36'(got_q.size()), 36'd0);
    we_n = 1'b1;
    model(0, 1, 0, 1, 8'h77);
    repeat (6) @(negedge clk);
    check("R10", 36'(got_q.size()), 36'd1);

    summary();
  end
endmodule